// File: doc/BRIEF.md
# Event Aggregator with Interrupt Router

This block turns single-cycle event pulses from many sources into a small set of level interrupt lines. Each source owns a steering entry that names the global event it emits. A per-event mapping entry then either sends that event to a trigger output or sets one bit of one 64-bit virtual interrupt status register. Each virtual interrupt ANDs its status with an enable mask and ORs the result into one aggregated line. A router then lets every output line pick any aggregated line, or stay off.

Software programs all tables through a simple write/read register port. It acknowledges interrupts by writing ones to status bits. No source is wired to a fixed interrupt, so any event can land on any bit of any virtual interrupt and reach any output.

Top module: `evagg_top`

## Requirements
- R1: A pulse on `ev_i[s]` while steering entry s is enabled (bit 31) sets the status bit chosen by the mapping entry of the event number in steering bits [GEV_W-1:0]. A pulse from a disabled source changes no status bit and no trigger.
- R2: A valid event whose mapping entry has the trigger flag (bit 30) set produces a one-cycle pulse on `trig_o[g]` one clock later. It sets no status bit.
- R3: An event whose mapping entry has the valid flag (bit 31) clear is dropped: no status bit and no trigger change.
- R4: Every bit 0..63 of every virtual interrupt can be targeted. The mapping holds the bit index in bits [5:0] and the virtual interrupt index in bits starting at 8. Pulses from several sources in one cycle all set their bits.
- R5: A virtual interrupt line is high exactly while some status bit is set with its mask bit set. It stays high as a level until the bit is cleared or masked.
- R6: A write to a status address clears each status bit written as 1. Bits written as 0 keep their value.
- R7: If a new event and a write-1-clear hit the same status bit in one cycle, the bit stays set.
- R8: Router output o drives the line of the virtual interrupt in select bits [VI_W-1:0] when its enable bit 31 is set, and drives 0 when the enable bit is clear.
- R9: A new event posted to an unmasked virtual interrupt shows on its routed output exactly one clock after the pulse is sampled, and not in the same cycle.
- R10: After reset, all table entries, status and mask registers read 0, and `trig_o` and `irq_o` are 0.
- R11: Every register reads back through `reg_rdata` with the address map below. The map is selected by address bits [7:6]: 0 = steering (index in [5:0]), 1 = mapping (index), 2 = virtual interrupt (v in [5:1]; [0]=0 status, [0]=1 mask), 3 = router output (index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| ev_i | input | NUM_SRC | Event pulses, one per source |
| trig_o | output | NUM_GEV | Trigger pulses, one per global event |
| irq_o | output | NUM_OUT | Routed interrupt lines |

## Verification
The aggregation path is first driven by a single source walked over all 64 bits and across the virtual interrupts, which exposes any bit or index decode slip. All sources are then fired together with distinct mappings, to expose lost or merged set terms. Directed patterns pit an event against a clear in the same cycle, against invalid and trigger-marked mappings, and against disabled sources, which separates the drop, trigger and set paths. The router is swept over all 16 line patterns and rotating selects with one output disabled each time, and the expected outputs are computed arithmetically.

// File: rtl/evagg_pkg.sv
`timescale 1ns/1ps
package evagg_pkg;
   typedef enum logic [1:0] {
      RG_STEER = 2'd0,
      RG_MAP   = 2'd1,
      RG_VINT  = 2'd2,
      RG_ROUTE = 2'd3
   } region_e;

   localparam int unsigned VINT_BITS = 64;
   localparam int unsigned EN_POS    = 31;
   localparam int unsigned TRIG_POS  = 30;
   localparam int unsigned VSEL_POS  = 8;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/evagg_steer.sv
`timescale 1ns/1ps
module evagg_steer
   import evagg_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned NUM_GEV  = 16,
   parameter int unsigned NUM_VINT = 4,
   parameter int unsigned IDX_W    = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               steer_we,
   input  logic                               map_we,
   input  logic [IDX_W-1:0]                   idx,
   input  logic [VINT_BITS-1:0]               wdata,
   input  logic [NUM_SRC-1:0]                 ev_i,
   output logic [VINT_BITS-1:0]               steer_rd,
   output logic [VINT_BITS-1:0]               map_rd,
   output logic [NUM_VINT-1:0][VINT_BITS-1:0] set_o,
   output logic [NUM_GEV-1:0]                 trig_o
);
   localparam int unsigned GEV_W = idx_w(NUM_GEV);
   localparam int unsigned VI_W  = idx_w(NUM_VINT);
   localparam int unsigned BIT_W = $clog2(VINT_BITS);

   logic [GEV_W-1:0]   src_gev_q [NUM_SRC];
   logic [NUM_SRC-1:0] src_en_q;
   logic [NUM_GEV-1:0] map_vld_q;
   logic [NUM_GEV-1:0] map_trg_q;
   logic [VI_W-1:0]    map_vi_q  [NUM_GEV];
   logic [BIT_W-1:0]   map_bit_q [NUM_GEV];
   logic [NUM_GEV-1:0] trig_hit;
   logic [NUM_GEV-1:0] trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en_q  <= '0;
         map_vld_q <= '0;
         map_trg_q <= '0;
         trig_q    <= '0;
         for (int s = 0; s < NUM_SRC; s++) src_gev_q[s] <= '0;
         for (int g = 0; g < NUM_GEV; g++) begin
            map_vi_q[g]  <= '0;
            map_bit_q[g] <= '0;
         end
      end else begin
         trig_q <= trig_hit;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (steer_we && idx == IDX_W'(s)) begin
               src_en_q[s]  <= wdata[EN_POS];
               src_gev_q[s] <= wdata[GEV_W-1:0];
            end
         end
         for (int g = 0; g < NUM_GEV; g++) begin
            if (map_we && idx == IDX_W'(g)) begin
               map_vld_q[g] <= wdata[EN_POS];
               map_trg_q[g] <= wdata[TRIG_POS];
               map_vi_q[g]  <= wdata[VSEL_POS +: VI_W];
               map_bit_q[g] <= wdata[BIT_W-1:0];
            end
         end
      end
   end

   // Indirection: source -> global event -> (trigger | vint bit)
   always_comb begin
      set_o    = '0;
      trig_hit = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (ev_i[s] && src_en_q[s] && (int'(src_gev_q[s]) < int'(NUM_GEV))) begin
            if (map_vld_q[src_gev_q[s]]) begin
               if (map_trg_q[src_gev_q[s]]) begin
                  trig_hit[src_gev_q[s]] = 1'b1;
               end else if (int'(map_vi_q[src_gev_q[s]]) < int'(NUM_VINT)) begin
                  set_o[map_vi_q[src_gev_q[s]]][map_bit_q[src_gev_q[s]]] = 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      steer_rd = '0;
      map_rd   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (idx == IDX_W'(s)) begin
            steer_rd[EN_POS]      = src_en_q[s];
            steer_rd[GEV_W-1:0]   = src_gev_q[s];
         end
      end
      for (int g = 0; g < NUM_GEV; g++) begin
         if (idx == IDX_W'(g)) begin
            map_rd[EN_POS]             = map_vld_q[g];
            map_rd[TRIG_POS]           = map_trg_q[g];
            map_rd[VSEL_POS +: VI_W]   = map_vi_q[g];
            map_rd[BIT_W-1:0]          = map_bit_q[g];
         end
      end
   end

   assign trig_o = trig_q;

   for (genvar g = 0; g < NUM_GEV; g++) begin : g_trig_chk
      AST_TRIG_FROM_MAP: assert property (@(posedge clk) disable iff (!rst_n)
         trig_o[g] |-> $past(map_vld_q[g] && map_trg_q[g])); // R2
   end
endmodule

// File: rtl/evagg_vint.sv
`timescale 1ns/1ps
module evagg_vint
   import evagg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VINT_BITS-1:0] set_i,
   input  logic                 clr_we,
   input  logic                 mask_we,
   input  logic [VINT_BITS-1:0] wdata,
   output logic [VINT_BITS-1:0] status_o,
   output logic [VINT_BITS-1:0] mask_o,
   output logic                 line_o
);
   logic [VINT_BITS-1:0] status_q;
   logic [VINT_BITS-1:0] mask_q;
   logic [VINT_BITS-1:0] clr_bits;

   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr_bits) | set_i;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign line_o   = |(status_q & mask_q);
   assign status_o = status_q;
   assign mask_o   = mask_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R7
   AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status_q) & ~status_q & ~$past(clr_bits)) == '0)); // R6
   AST_LINE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(set_i & mask_q)) && !mask_we) |=> line_o); // R9
endmodule

// File: rtl/evagg_router.sv
`timescale 1ns/1ps
module evagg_router
   import evagg_pkg::*;
#(
   parameter int unsigned NUM_VINT = 4,
   parameter int unsigned NUM_OUT  = 4,
   parameter int unsigned IDX_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IDX_W-1:0]     idx,
   input  logic [VINT_BITS-1:0] wdata,
   input  logic [NUM_VINT-1:0]  line_i,
   output logic [VINT_BITS-1:0] rd_o,
   output logic [NUM_OUT-1:0]   irq_o
);
   localparam int unsigned VI_W = idx_w(NUM_VINT);

   logic [VI_W-1:0]    sel_q [NUM_OUT];
   logic [NUM_OUT-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         for (int o = 0; o < NUM_OUT; o++) sel_q[o] <= '0;
      end else begin
         for (int o = 0; o < NUM_OUT; o++) begin
            if (we && idx == IDX_W'(o)) begin
               en_q[o]  <= wdata[EN_POS];
               sel_q[o] <= wdata[VI_W-1:0];
            end
         end
      end
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign irq_o[o] = en_q[o] && (int'(sel_q[o]) < int'(NUM_VINT)) && line_i[sel_q[o]];
   end

   always_comb begin
      rd_o = '0;
      for (int o = 0; o < NUM_OUT; o++) begin
         if (idx == IDX_W'(o)) begin
            rd_o[EN_POS]    = en_q[o];
            rd_o[VI_W-1:0]  = sel_q[o];
         end
      end
   end

   AST_OUT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_o) |-> (|line_i)); // R8
endmodule

// File: rtl/evagg_top.sv
`timescale 1ns/1ps
module evagg_top
   import evagg_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned NUM_GEV  = 16,
   parameter int unsigned NUM_VINT = 4,
   parameter int unsigned NUM_OUT  = 4,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [VINT_BITS-1:0] reg_wdata,
   output logic [VINT_BITS-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0]   ev_i,
   output logic [NUM_GEV-1:0]   trig_o,
   output logic [NUM_OUT-1:0]   irq_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam int unsigned VX_W  = IDX_W - 1;
   localparam int unsigned VI_W  = idx_w(NUM_VINT);

   if (ADDR_W < 4 || NUM_SRC > (1 << IDX_W) || NUM_GEV > (1 << IDX_W) ||
       NUM_OUT > (1 << IDX_W) || NUM_VINT > (1 << VX_W) ||
       VI_W > (TRIG_POS - VSEL_POS)) begin : g_bad_cfg
      $error("evagg_top: table sizes do not fit the address or field layout");
   end

   region_e                           region;
   logic [IDX_W-1:0]                  idx;
   logic [VX_W-1:0]                   vidx;
   logic [NUM_VINT-1:0][VINT_BITS-1:0] set_v;
   logic [VINT_BITS-1:0]              status_v [NUM_VINT];
   logic [VINT_BITS-1:0]              mask_v   [NUM_VINT];
   logic [NUM_VINT-1:0]               line_v;
   logic [VINT_BITS-1:0]              steer_rd, map_rd, route_rd;

   assign region = region_e'(reg_addr[ADDR_W-1 -: 2]);
   assign idx    = reg_addr[IDX_W-1:0];
   assign vidx   = reg_addr[IDX_W-1:1];

   evagg_steer #(
      .NUM_SRC (NUM_SRC),
      .NUM_GEV (NUM_GEV),
      .NUM_VINT(NUM_VINT),
      .IDX_W   (IDX_W)
   ) i_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .steer_we(reg_we && region == RG_STEER),
      .map_we  (reg_we && region == RG_MAP),
      .idx     (idx),
      .wdata   (reg_wdata),
      .ev_i    (ev_i),
      .steer_rd(steer_rd),
      .map_rd  (map_rd),
      .set_o   (set_v),
      .trig_o  (trig_o)
   );

   for (genvar v = 0; v < NUM_VINT; v++) begin : g_vint
      logic hit;
      assign hit = reg_we && region == RG_VINT && vidx == VX_W'(v);
      evagg_vint i_vint (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (set_v[v]),
         .clr_we  (hit && !reg_addr[0]),
         .mask_we (hit && reg_addr[0]),
         .wdata   (reg_wdata),
         .status_o(status_v[v]),
         .mask_o  (mask_v[v]),
         .line_o  (line_v[v])
      );
   end

   evagg_router #(
      .NUM_VINT(NUM_VINT),
      .NUM_OUT (NUM_OUT),
      .IDX_W   (IDX_W)
   ) i_router (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && region == RG_ROUTE),
      .idx   (idx),
      .wdata (reg_wdata),
      .line_i(line_v),
      .rd_o  (route_rd),
      .irq_o (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (region)
         RG_STEER: reg_rdata = steer_rd;
         RG_MAP:   reg_rdata = map_rd;
         RG_ROUTE: reg_rdata = route_rd;
         RG_VINT: begin
            for (int v = 0; v < NUM_VINT; v++) begin
               if (vidx == VX_W'(v)) reg_rdata = reg_addr[0] ? mask_v[v] : status_v[v];
            end
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: tb/test_evagg_top.sv
`timescale 1ns/1ps
module test_evagg_top;
   localparam int NS = 8, NG = 16, NV = 4, NO = 4;
   localparam logic [63:0] EN = 64'h8000_0000, TRG = 64'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [NS-1:0] ev_i = '0;
   logic [NG-1:0] trig_o;
   logic [NO-1:0] irq_o;
   int total = 0, fails = 0;

   always #2 clk = ~clk;

   evagg_top i_evagg_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_i(ev_i),
      .trig_o(trig_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NS-1:0] m);
      @(negedge clk);
      ev_i = m;
      @(negedge clk);
      ev_i = '0;
   endtask

   function automatic logic [7:0] a_st(input int v); return 8'h80 + 8'(2*v); endfunction
   function automatic logic [7:0] a_mk(input int v); return 8'h81 + 8'(2*v); endfunction
   function automatic logic [63:0] mapw(input int v, input int b); return EN | (64'(v) << 8) | 64'(b); endfunction

   task automatic clear_all();
      for (int v = 0; v < NV; v++) wr(a_st(v), '1);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] d;
      logic [63:0] exp_v [NV];
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 irq", 64'(irq_o), 0);
      chk("R10 trig", 64'(trig_o), 0);
      for (int i = 0; i < NS; i++) begin rd(8'(i), d); chk("R10 steer", d, 0); end
      for (int i = 0; i < NG; i++) begin rd(8'h40 + 8'(i), d); chk("R10 map", d, 0); end
      for (int v = 0; v < NV; v++) begin
         rd(a_st(v), d); chk("R10 status", d, 0);
         rd(a_mk(v), d); chk("R10 mask", d, 0);
      end
      for (int o = 0; o < NO; o++) begin rd(8'hC0 + 8'(o), d); chk("R10 route", d, 0); end
      rst_n = 1'b1;
      @(negedge clk);

      // R11: readback
      wr(8'h03, EN | 64'd5);  rd(8'h03, d); chk("R11 steer", d, EN | 64'd5);
      wr(8'h45, EN | TRG | (64'd2 << 8) | 64'd37); rd(8'h45, d);
      chk("R11 map", d, EN | TRG | (64'd2 << 8) | 64'd37);
      wr(8'hC2, EN | 64'd3); rd(8'hC2, d); chk("R11 route", d, EN | 64'd3);
      wr(a_mk(1), 64'hDEAD_BEEF_0123_4567); rd(a_mk(1), d); chk("R11 mask", d, 64'hDEAD_BEEF_0123_4567);
      wr(8'h45, 0); wr(a_mk(1), 0); wr(8'hC2, 0);

      // R4 / R1: walk one source over every bit, rotating the vint
      wr(8'h00, EN | 64'd0);
      for (int b = 0; b < 64; b++) begin
         wr(8'h40, mapw(b % NV, b));
         pulse(8'h01);
         for (int v = 0; v < NV; v++) begin
            rd(a_st(v), d);
            chk("R4 bit sweep", d, (v == b % NV) ? (64'd1 << b) : 64'd0);
         end
         wr(a_st(b % NV), '1);
      end

      // R1 / R4: all sources together, distinct targets
      for (int v = 0; v < NV; v++) exp_v[v] = 0;
      for (int s = 0; s < NS; s++) begin
         wr(8'(s), EN | 64'(s + 8));
         wr(8'h40 + 8'(s + 8), mapw(s % NV, 2 * s + 1));
         exp_v[s % NV] |= 64'd1 << (2 * s + 1);
      end
      pulse('1);
      for (int v = 0; v < NV; v++) begin rd(a_st(v), d); chk("R1 all sources", d, exp_v[v]); end
      clear_all();
      // R1: disabled source ignored
      wr(8'h07, 64'd15);
      pulse(8'h80);
      for (int v = 0; v < NV; v++) begin rd(a_st(v), d); chk("R1 disabled source", d, 0); end
      chk("R1 disabled trig", 64'(trig_o), 0);

      // R3: invalid mapping dropped
      wr(8'h40 + 8'd14, 64'(2) << 8 | 64'd9);
      pulse(8'h40);
      for (int v = 0; v < NV; v++) begin rd(a_st(v), d); chk("R3 invalid drop", d, 0); end
      chk("R3 no trig", 64'(trig_o), 0);

      // R2: trigger-marked event
      wr(8'h40 + 8'd13, EN | TRG | (64'd1 << 8) | 64'd4);
      pulse(8'h20);
      chk("R2 trig pulse", 64'(trig_o), 64'd1 << 13);
      for (int v = 0; v < NV; v++) begin rd(a_st(v), d); chk("R2 no status", d, 0); end
      @(negedge clk);
      chk("R2 trig one cycle", 64'(trig_o), 0);

      // R5 / R8: mask gating and level line
      wr(8'hC0, EN | 64'd1);
      pulse(8'h02);                      // src1 -> gev9 -> vint1 bit3
      chk("R5 masked low", 64'(irq_o), 0);
      wr(a_mk(1), 64'd1 << 3);
      chk("R5 unmasked high", 64'(irq_o[0]), 1);
      repeat (5) @(negedge clk);
      chk("R5 level holds", 64'(irq_o[0]), 1);
      wr(a_mk(1), ~(64'd1 << 3));
      chk("R5 other mask low", 64'(irq_o[0]), 0);
      wr(a_mk(1), '1);

      // R6: write-1-clear selectivity
      pulse(8'h08);                      // src3 -> gev11 -> vint3 bit7
      wr(8'hC1, EN | 64'd3);
      wr(a_st(1), 64'd0);
      rd(a_st(1), d); chk("R6 zero write", d, 64'd1 << 3);
      wr(a_st(1), 64'd1 << 3);
      rd(a_st(1), d); chk("R6 clear bit", d, 0);
      chk("R5 line drops", 64'(irq_o[0]), 0);
      rd(a_st(3), d); chk("R6 other vint", d, 64'd1 << 7);
      wr(a_st(3), '1);

      // R9: exactly one clock latency (vint1 bit3, out0, mask set)
      @(negedge clk);
      ev_i = 8'h02;
      #1 chk("R9 not same cycle", 64'(irq_o[0]), 0);
      @(negedge clk);
      ev_i = '0;
      chk("R9 one clock", 64'(irq_o[0]), 1);

      // R7: set and clear of the same bit in one cycle
      @(negedge clk);
      ev_i = 8'h02; reg_we = 1'b1; reg_addr = a_st(1); reg_wdata = '1;
      @(negedge clk);
      ev_i = '0; reg_we = 1'b0;
      rd(a_st(1), d); chk("R7 set wins", d, 64'd1 << 3);
      clear_all();

      // R8: router sweep, vint v bit0 from source v
      for (int v = 0; v < NV; v++) wr(8'h40 + 8'(v + 8), mapw(v, 0));
      pulse(8'h0F);
      for (int p = 0; p < 16; p++) begin
         for (int v = 0; v < NV; v++) wr(a_mk(v), p[v] ? 64'd1 : 64'd0);
         for (int k = 0; k < NO; k++) begin
            logic [NO-1:0] e;
            e = '0;
            for (int o = 0; o < NO; o++) begin
               wr(8'hC0 + 8'(o), ((o == k) ? 64'd0 : EN) | 64'((o + k) % NV));
               e[o] = (o != k) && p[(o + k) % NV];
            end
            chk("R8 router", 64'(irq_o), 64'(e));
         end
      end

      finish_run();
   end
endmodule